// File: doc/BRIEF.md
# Single-Bit Boolean Execution Unit

This unit carries out one-bit logic operations for a small controller core. It holds a one-bit carry flag. It works on a single bit picked out of a byte-wide storage space, where the lowest bytes stand for I/O ports. A decoder upstream supplies an operation code, a target flag, a bit address, an address-form flag and a timing-mode flag, and then pulses `start`. The unit latches the request and stays busy for a fixed number of states. That number depends on the operation class, the address form, the mode and whether the addressed byte is a port. In its last state the unit raises `done` for one cycle and commits the new carry and, where the operation writes, the modified byte.

The byte space is a simple register-file model. A host load port fills it and a peek port reads it. These ports let the unit be exercised and observed on its own.

Top module: `bp_exec`

## Requirements
- R1: After synchronous reset, `carry` is 0, `busy` and `done` are 0, and every byte of the storage space reads 0.
- R2: Operation codes 0 (clear), 1 (set) and 2 (complement) with `to_bit`=0 act on the carry alone. They take 1 state in every form and mode, and the byte space is left unchanged. The carry changes only on the commit edge.
- R3: Codes 0, 1 and 2 with `to_bit`=1 clear, set or complement the bit at `bit_addr`. Byte address `bit_addr[7:3]` selects the byte and `bit_addr[2:0]` selects the bit. Only that bit changes and the whole byte is written back.
- R4: Codes 3 (AND), 4 (AND with inverted bit), 5 (OR) and 6 (OR with inverted bit) compute carry op bit, or carry op NOT bit, into the carry. The addressed byte keeps its value.
- R5: Code 7 moves data. With `to_bit`=0 it copies the addressed bit into the carry. With `to_bit`=1 it copies the carry into the addressed bit.
- R6: Operations that write a bit take 2 states in the short form (`long_form`=0). In the long form they take 4 states in binary mode (`src_mode`=0) and 3 in source mode.
- R7: Operations that only read the bit into the carry (codes 3 to 6, and code 7 with `to_bit`=0) take 1 state in the short form. In the long form they take 3 states in binary mode and 2 in source mode.
- R8: When the addressed byte is one of the four port bytes (byte addresses 0 to 3), bit-writing operations take 2 extra states and bit-reading operations take 1 extra state. Carry-only operations get no extra state.
- R9: `busy` is high from the cycle after `start` is accepted through the final state. `done` is a one-cycle pulse in that final state, and the results become visible on the following cycle.
- R10: A `start` that arrives while `busy` is high, including the `done` cycle, is ignored. It neither restarts nor queues an operation.
- R11: A host load (`ld_en`) writes `ld_data` to byte `ld_addr` on the next edge when the unit is idle. A host load made while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| op | input | 3 | Operation code 0..7 |
| to_bit | input | 1 | 1: direct bit is the destination; 0: carry |
| long_form | input | 1 | Long (extended) address form |
| src_mode | input | 1 | 1: source timing mode; 0: binary |
| bit_addr | input | 8 | Byte address [7:3], bit index [2:0] |
| ld_en | input | 1 | Host byte load strobe |
| ld_addr | input | 5 | Host load byte address |
| ld_data | input | 8 | Host load data |
| peek_addr | input | 5 | Observation byte address |
| peek_data | output | 8 | Byte at `peek_addr` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Final-state pulse |
| carry | output | 1 | Carry flag |

## Verification
The final state of an operation can coincide with a new `start` strobe, and a host byte load can coincide with a running operation. The bench holds `start` high across a whole long-form write, through its `done` cycle, and fires `ld_en` at the same target byte midway. It then requires exactly one commit with the correct duration, an idle unit one cycle later, an unchanged carry, and a byte that shows only the bit change and none of the load data.

// File: rtl/bitproc_pkg.sv
`timescale 1ns/1ps
package bitproc_pkg;

    localparam int BIT_IDX_W = 3;
    localparam int CNT_W     = 3;
    localparam int MAX_STATES = 6;

    // base state counts per class / form / mode
    localparam int ST_CARRY      = 1;
    localparam int ST_WR_SHORT   = 2;
    localparam int ST_WR_LONG_B  = 4;
    localparam int ST_WR_LONG_S  = 3;
    localparam int ST_RD_SHORT   = 1;
    localparam int ST_RD_LONG_B  = 3;
    localparam int ST_RD_LONG_S  = 2;
    localparam int ST_WR_PORT_EX = 2;
    localparam int ST_RD_PORT_EX = 1;

    typedef logic [CNT_W-1:0] bp_cnt_t;

    typedef enum logic [2:0] {
        OP_CLR  = 3'd0,
        OP_SET  = 3'd1,
        OP_CPL  = 3'd2,
        OP_AND  = 3'd3,
        OP_ANDN = 3'd4,
        OP_OR   = 3'd5,
        OP_ORN  = 3'd6,
        OP_MOV  = 3'd7
    } bp_op_e;

    typedef enum logic [1:0] {
        CLS_CARRY = 2'd0,
        CLS_WRITE = 2'd1,
        CLS_READ  = 2'd2
    } bp_cls_e;

    typedef struct packed {
        bp_op_e op;
        logic   to_bit;
        logic   long_f;
        logic   src_m;
    } bp_req_t;

    function automatic bp_cls_e bp_classify(bp_op_e op, logic to_bit);
        bp_cls_e c;
        case (op)
            OP_CLR, OP_SET, OP_CPL: c = to_bit ? CLS_WRITE : CLS_CARRY;
            OP_MOV:                 c = to_bit ? CLS_WRITE : CLS_READ;
            default:                c = CLS_READ;
        endcase
        return c;
    endfunction

    function automatic bp_cnt_t bp_states(bp_cls_e cls, logic long_f,
                                          logic src_m, logic in_port);
        int n;
        case (cls)
            CLS_WRITE: begin
                n = long_f ? (src_m ? ST_WR_LONG_S : ST_WR_LONG_B) : ST_WR_SHORT;
                if (in_port) n = n + ST_WR_PORT_EX;
            end
            CLS_READ: begin
                n = long_f ? (src_m ? ST_RD_LONG_S : ST_RD_LONG_B) : ST_RD_SHORT;
                if (in_port) n = n + ST_RD_PORT_EX;
            end
            default: n = ST_CARRY;
        endcase
        return bp_cnt_t'(n);
    endfunction

endpackage

// File: rtl/bp_timing.sv
`timescale 1ns/1ps
module bp_timing
    import bitproc_pkg::*;
#(
    parameter int BYTE_AW   = 5,
    parameter int PORT_BASE = 0,
    parameter int NUM_PORTS = 4
) (
    input  bp_op_e             op,
    input  logic               to_bit,
    input  logic               long_f,
    input  logic               src_m,
    input  logic [BYTE_AW-1:0] byte_addr,
    output bp_cls_e            cls,
    output bp_cnt_t            n_states
);
    logic [BYTE_AW-1:0] port_off;
    logic               in_port;

    always_comb begin
        port_off = byte_addr - BYTE_AW'(PORT_BASE);
        in_port  = (port_off < BYTE_AW'(NUM_PORTS));
        cls      = bp_classify(op, to_bit);
        n_states = bp_states(cls, long_f, src_m, in_port);
    end
endmodule

// File: rtl/bp_alu.sv
`timescale 1ns/1ps
module bp_alu
    import bitproc_pkg::*;
(
    input  bp_op_e               op,
    input  logic                 to_bit,
    input  logic                 carry_in,
    input  logic [7:0]           byte_in,
    input  logic [BIT_IDX_W-1:0] bit_idx,
    output logic                 carry_out,
    output logic [7:0]           byte_out,
    output logic                 byte_we
);
    logic bit_v;

    always_comb begin
        bit_v     = byte_in[bit_idx];
        carry_out = carry_in;
        byte_out  = byte_in;
        byte_we   = 1'b0;
        case (op)
            OP_CLR: if (to_bit) begin byte_out[bit_idx] = 1'b0; byte_we = 1'b1; end
                    else carry_out = 1'b0;
            OP_SET: if (to_bit) begin byte_out[bit_idx] = 1'b1; byte_we = 1'b1; end
                    else carry_out = 1'b1;
            OP_CPL: if (to_bit) begin byte_out[bit_idx] = ~bit_v; byte_we = 1'b1; end
                    else carry_out = ~carry_in;
            OP_AND:  carry_out = carry_in & bit_v;
            OP_ANDN: carry_out = carry_in & ~bit_v;
            OP_OR:   carry_out = carry_in | bit_v;
            OP_ORN:  carry_out = carry_in | ~bit_v;
            OP_MOV: if (to_bit) begin byte_out[bit_idx] = carry_in; byte_we = 1'b1; end
                    else carry_out = bit_v;
            default: ;
        endcase
    end
endmodule

// File: rtl/bp_bytes.sv
`timescale 1ns/1ps
module bp_bytes #(
    parameter int BYTE_AW = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [BYTE_AW-1:0] waddr,
    input  logic [7:0]         wdata,
    input  logic [BYTE_AW-1:0] raddr_a,
    output logic [7:0]         rdata_a,
    input  logic [BYTE_AW-1:0] raddr_b,
    output logic [7:0]         rdata_b
);
    localparam int DEPTH = 2 ** BYTE_AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/bp_exec.sv
`timescale 1ns/1ps
module bp_exec
    import bitproc_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int PORT_BASE = 0,
    parameter int NUM_PORTS = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic [2:0]                  op,
    input  logic                        to_bit,
    input  logic                        long_form,
    input  logic                        src_mode,
    input  logic [ADDR_W-1:0]           bit_addr,
    input  logic                        ld_en,
    input  logic [ADDR_W-BIT_IDX_W-1:0] ld_addr,
    input  logic [7:0]                  ld_data,
    input  logic [ADDR_W-BIT_IDX_W-1:0] peek_addr,
    output logic [7:0]                  peek_data,
    output logic                        busy,
    output logic                        done,
    output logic                        carry
);
    localparam int BYTE_AW = ADDR_W - BIT_IDX_W;

    bp_req_t             req_q;
    logic [ADDR_W-1:0]   addr_q;
    bp_cnt_t             cnt_q;
    bp_cnt_t             total_q;
    logic                busy_q;
    logic                carry_q;

    bp_cls_e             cls_in;
    bp_cnt_t             n_in;
    logic [7:0]          byte_rd;
    logic                carry_nxt;
    logic [7:0]          byte_nxt;
    logic                alu_we;
    logic                done_w;

    logic                mem_we;
    logic [BYTE_AW-1:0]  mem_waddr;
    logic [7:0]          mem_wdata;

    bp_timing #(
        .BYTE_AW  (BYTE_AW),
        .PORT_BASE(PORT_BASE),
        .NUM_PORTS(NUM_PORTS)
    ) u_timing (
        .op       (bp_op_e'(op)),
        .to_bit   (to_bit),
        .long_f   (long_form),
        .src_m    (src_mode),
        .byte_addr(bit_addr[ADDR_W-1:BIT_IDX_W]),
        .cls      (cls_in),
        .n_states (n_in)
    );

    bp_alu u_alu (
        .op       (req_q.op),
        .to_bit   (req_q.to_bit),
        .carry_in (carry_q),
        .byte_in  (byte_rd),
        .bit_idx  (addr_q[BIT_IDX_W-1:0]),
        .carry_out(carry_nxt),
        .byte_out (byte_nxt),
        .byte_we  (alu_we)
    );

    assign done_w = busy_q && (cnt_q == total_q);

    always_comb begin
        mem_we    = 1'b0;
        mem_waddr = ld_addr;
        mem_wdata = ld_data;
        if (done_w && alu_we) begin
            mem_we    = 1'b1;
            mem_waddr = addr_q[ADDR_W-1:BIT_IDX_W];
            mem_wdata = byte_nxt;
        end else if (!busy_q && ld_en) begin
            mem_we    = 1'b1;
        end
    end

    bp_bytes #(.BYTE_AW(BYTE_AW)) u_bytes (
        .clk    (clk),
        .rst    (rst),
        .we     (mem_we),
        .waddr  (mem_waddr),
        .wdata  (mem_wdata),
        .raddr_a(addr_q[ADDR_W-1:BIT_IDX_W]),
        .rdata_a(byte_rd),
        .raddr_b(peek_addr),
        .rdata_b(peek_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= '{op: OP_CLR, to_bit: 1'b0, long_f: 1'b0, src_m: 1'b0};
            addr_q  <= '0;
            cnt_q   <= '0;
            total_q <= '0;
            busy_q  <= 1'b0;
            carry_q <= 1'b0;
        end else if (!busy_q) begin
            if (start) begin
                req_q   <= '{op: bp_op_e'(op), to_bit: to_bit,
                             long_f: long_form, src_m: src_mode};
                addr_q  <= bit_addr;
                total_q <= n_in;
                cnt_q   <= bp_cnt_t'(1);
                busy_q  <= 1'b1;
            end
        end else if (done_w) begin
            busy_q  <= 1'b0;
            cnt_q   <= '0;
            carry_q <= carry_nxt;
        end else begin
            cnt_q   <= cnt_q + bp_cnt_t'(1);
        end
    end

    assign busy  = busy_q;
    assign done  = done_w;
    assign carry = carry_q;

    logic unused_cls;
    assign unused_cls = ^cls_in;
endmodule

// File: rtl/bp_exec_chk.sv
`timescale 1ns/1ps
module bp_exec_chk
    import bitproc_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    busy,
    input logic    done,
    input logic    carry,
    input bp_cnt_t cnt,
    input bp_cnt_t total
);
    AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                             // R9
    AST_DONE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);                                              // R9
    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);                                             // R10
    AST_CARRY_HELD: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(carry));                                   // R2
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> (busy && cnt == bp_cnt_t'($past(cnt) + 1'b1))); // R10
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt != '0 && cnt <= total));                       // R6
    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> (total >= bp_cnt_t'(1) && total <= bp_cnt_t'(MAX_STATES))); // R8
endmodule

bind bp_exec bp_exec_chk i_bp_exec_chk (
    .clk  (clk),
    .rst  (rst),
    .busy (busy_q),
    .done (done_w),
    .carry(carry_q),
    .cnt  (cnt_q),
    .total(total_q)
);

// File: tb/test_bp_exec.sv
`timescale 1ns/1ps
module test_bp_exec;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [2:0] op = 3'd0;
    logic       to_bit = 1'b0;
    logic       long_form = 1'b0;
    logic       src_mode = 1'b0;
    logic [7:0] bit_addr = 8'd0;
    logic       ld_en = 1'b0;
    logic [4:0] ld_addr = 5'd0;
    logic [7:0] ld_data = 8'd0;
    logic [4:0] peek_addr = 5'd0;
    logic [7:0] peek_data;
    logic       busy, done, carry;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    bp_exec i_bp_exec (
        .clk(clk), .rst(rst), .start(start), .op(op), .to_bit(to_bit),
        .long_form(long_form), .src_mode(src_mode), .bit_addr(bit_addr),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .peek_addr(peek_addr), .peek_data(peek_data),
        .busy(busy), .done(done), .carry(carry)
    );

    localparam logic [2:0] C_CLR = 3'd0, C_SET = 3'd1, C_CPL = 3'd2, C_AND = 3'd3,
                           C_ANDN = 3'd4, C_OR = 3'd5, C_ORN = 3'd6, C_MOV = 3'd7;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic peek(input logic [4:0] a, output logic [7:0] d);
        peek_addr = a;
        #0.5;
        d = peek_data;
    endtask

    task automatic load_byte(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic run_op(input logic [2:0] o, input logic tb, input logic lf,
                          input logic sm, input logic [7:0] a, output int n);
        @(negedge clk);
        op = o; to_bit = tb; long_form = lf; src_mode = sm; bit_addr = a;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 20) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R1", "carry", carry, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        peek(5'd5, d);
        chk("R1", "byte5", d, 0);
        peek(5'd31, d);
        chk("R1", "byte31", d, 0);
    endtask

    task automatic t_load;
        logic [7:0] d;
        load_byte(5'd9, 8'hA5);
        load_byte(5'd31, 8'h5A);
        peek(5'd9, d);  chk("R11", "load byte9", d, 8'hA5);
        peek(5'd31, d); chk("R11", "load byte31", d, 8'h5A);
    endtask

    task automatic t_carry_ops;
        int n; logic [7:0] d;
        run_op(C_SET, 1'b0, 1'b0, 1'b0, 8'd73, n);
        chk("R2", "set carry", carry, 1); chk("R2", "set carry states", n, 1);
        run_op(C_CPL, 1'b0, 1'b1, 1'b0, 8'd73, n);
        chk("R2", "cpl carry", carry, 0); chk("R2", "cpl long states", n, 1);
        run_op(C_CPL, 1'b0, 1'b1, 1'b1, 8'd73, n);
        chk("R2", "cpl carry again", carry, 1);
        run_op(C_CLR, 1'b0, 1'b0, 1'b0, 8'd73, n);
        chk("R2", "clr carry", carry, 0);
        peek(5'd9, d); chk("R2", "byte untouched", d, 8'hA5);
    endtask

    task automatic t_bit_ops;
        int n; logic [7:0] d;
        run_op(C_SET, 1'b1, 1'b0, 1'b0, 8'd73, n);     // byte 9 bit 1
        peek(5'd9, d); chk("R3", "set bit1", d, 8'hA7);
        chk("R6", "short write states", n, 2);
        run_op(C_CLR, 1'b1, 1'b0, 1'b1, 8'd72, n);     // bit 0
        peek(5'd9, d); chk("R3", "clr bit0", d, 8'hA6);
        chk("R6", "short write src states", n, 2);
        run_op(C_CPL, 1'b1, 1'b0, 1'b0, 8'd79, n);     // bit 7
        peek(5'd9, d); chk("R3", "cpl bit7", d, 8'h26);
        run_op(C_CPL, 1'b1, 1'b1, 1'b0, 8'd83, n);     // byte 10 bit 3
        peek(5'd10, d); chk("R3", "cpl long bin", d, 8'h08);
        chk("R6", "long bin write states", n, 4);
        run_op(C_CPL, 1'b1, 1'b1, 1'b1, 8'd83, n);
        peek(5'd10, d); chk("R3", "cpl long src", d, 8'h00);
        chk("R6", "long src write states", n, 3);
        chk("R3", "carry kept", carry, 0);
    endtask

    task automatic t_logic;
        int n; logic [7:0] d;
        // byte 9 = 0x26: bit0 = 0, bit1 = 1
        run_op(C_SET, 1'b0, 1'b0, 1'b0, 8'd0, n);
        run_op(C_AND, 1'b0, 1'b0, 1'b0, 8'd72, n);
        chk("R4", "and bit0", carry, 0); chk("R7", "short read states", n, 1);
        run_op(C_SET, 1'b0, 1'b0, 1'b0, 8'd0, n);
        run_op(C_ANDN, 1'b0, 1'b1, 1'b0, 8'd72, n);
        chk("R4", "andn bit0", carry, 1); chk("R7", "long bin read states", n, 3);
        run_op(C_ANDN, 1'b0, 1'b0, 1'b0, 8'd73, n);
        chk("R4", "andn bit1", carry, 0);
        run_op(C_OR, 1'b0, 1'b1, 1'b1, 8'd73, n);
        chk("R4", "or bit1", carry, 1); chk("R7", "long src read states", n, 2);
        run_op(C_CLR, 1'b0, 1'b0, 1'b0, 8'd0, n);
        run_op(C_ORN, 1'b0, 1'b0, 1'b0, 8'd73, n);
        chk("R4", "orn bit1", carry, 0);
        run_op(C_ORN, 1'b0, 1'b0, 1'b0, 8'd72, n);
        chk("R4", "orn bit0", carry, 1);
        peek(5'd9, d); chk("R4", "source bit unchanged", d, 8'h26);
    endtask

    task automatic t_mov;
        int n; logic [7:0] d;
        run_op(C_CLR, 1'b0, 1'b0, 1'b0, 8'd0, n);
        run_op(C_MOV, 1'b0, 1'b0, 1'b0, 8'd73, n);
        chk("R5", "bit to carry", carry, 1); chk("R7", "mov read states", n, 1);
        run_op(C_MOV, 1'b1, 1'b0, 1'b0, 8'd76, n);     // carry -> bit 4
        peek(5'd9, d); chk("R5", "carry to bit", d, 8'h36);
        chk("R6", "mov write states", n, 2);
        run_op(C_MOV, 1'b1, 1'b1, 1'b0, 8'd76, n);
        chk("R6", "mov long bin write states", n, 4);
    endtask

    task automatic t_ports;
        int n; logic [7:0] d;
        run_op(C_SET, 1'b1, 1'b0, 1'b0, 8'd21, n);     // byte 2 bit 5
        peek(5'd2, d); chk("R8", "port set", d, 8'h20);
        chk("R8", "port short write", n, 4);
        run_op(C_CLR, 1'b1, 1'b1, 1'b0, 8'd21, n);
        chk("R8", "port long bin write", n, 6);
        run_op(C_CPL, 1'b1, 1'b1, 1'b1, 8'd0, n);      // byte 0
        chk("R8", "port long src write", n, 5);
        run_op(C_AND, 1'b0, 1'b0, 1'b0, 8'd31, n);     // byte 3
        chk("R8", "port short read", n, 2);
        run_op(C_OR, 1'b0, 1'b1, 1'b0, 8'd31, n);
        chk("R8", "port long bin read", n, 4);
        run_op(C_MOV, 1'b0, 1'b1, 1'b1, 8'd31, n);
        chk("R8", "port long src read", n, 3);
        run_op(C_CPL, 1'b0, 1'b1, 1'b0, 8'd21, n);
        chk("R8", "port carry-only", n, 1);
        run_op(C_SET, 1'b1, 1'b0, 1'b0, 8'd32, n);     // byte 4: not a port
        chk("R8", "byte4 not port", n, 2);
    endtask

    task automatic t_overlap;
        logic [7:0] d; logic c0; int n;
        c0 = carry;
        @(negedge clk);
        op = C_SET; to_bit = 1'b1; long_form = 1'b1; src_mode = 1'b0;
        bit_addr = 8'd86;                              // byte 10 bit 6
        start = 1'b1;
        @(negedge clk);
        n = 1;
        op = C_CPL; to_bit = 1'b0; bit_addr = 8'd80;   // start held, other op
        ld_en = 1'b1; ld_addr = 5'd10; ld_data = 8'hFF;
        @(negedge clk);
        ld_en = 1'b0;
        n++;
        while (!done && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk("R9", "overlap length", n, 4);
        @(negedge clk);                                // start still high at done edge
        start = 1'b0;
        chk("R10", "idle after done", busy, 0);
        chk("R9", "done pulse ended", done, 0);
        @(negedge clk);
        chk("R10", "no queued op", busy, 0);
        chk("R10", "carry untouched", carry, c0);
        peek(5'd10, d);
        chk("R11", "load while busy ignored", d, 8'h40);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_load();
        t_carry_ops();
        t_bit_ops();
        t_logic();
        t_mov();
        t_ports();
        t_overlap();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule